// File: doc/BRIEF.md
# Segmented address generation unit

This block turns an offset from the execution pipeline into a linear address. It holds six segment registers, numbered CS, DS, SS, ES, FS and GS. Each register holds a base, a 16-bit limit and a valid flag. For every request the block chooses a segment from the kind of access and an optional override. It then either adds the segment base to the offset, or reports a fault.

Two addressing modes are chosen per request. In segmented mode only the low 16 bits of the offset count. The whole access, from its first byte to its last, must fit inside the segment limit. In flat mode the full offset passes through, and only FS and GS add their base. Segment registers are loaded through a single write port. Requests and responses each use a valid/ready handshake, and the response register adds one cycle of latency.

Top module: `seg_agu`

## Requirements
- R1: The default segment follows `req_kind`. Kind 0 (instruction fetch) selects CS, kind 2 (stack) selects SS and kind 1 (plain data) selects DS. The segment used is reported on `rsp_seg` as CS=0, DS=1, SS=2, ES=3, FS=4, GS=5.
- R2: For kind 1 only, `req_ovr` redirects the access: 1 selects ES, 2 selects FS, 3 selects GS and 0 keeps DS. The override has no effect on fetch or stack accesses.
- R3: Kind 3 (string destination) always uses ES, whatever the value of `req_ovr`.
- R4: In segmented mode (`req_mode64`=0) the address is the segment base plus the zero-extended `req_offset[15:0]`, modulo 2^ADDR_W. The upper offset bits are ignored.
- R5: In segmented mode, a limit fault is raised when offset[15:0] + `req_size_m1` is greater than the segment limit. The sum is taken with 17 bits, so an access that wraps past 0xFFFF also faults. The limit is the offset of the last byte, so segment sizes range from 1 to 65536 bytes. A faulting response carries address 0.
- R6: In flat mode (`req_mode64`=1) the address equals the full offset for CS, DS, SS and ES. For FS and GS it is the base plus the offset.
- R7: In flat mode `rsp_limit_fault` stays low for every offset and size.
- R8: In either mode, using a segment whose valid flag is clear raises `rsp_inval_fault`. It also forces `rsp_limit_fault` low and the address to 0.
- R9: When `wr_en` is high, a clock edge loads base, limit and valid flag into the register numbered `wr_sel`. Requests accepted on later edges see the new values. `wr_sel` values 6 and 7 change nothing.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready`. An accepted request appears on the response one clock later. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady.
- R11: After reset `rsp_valid` is low and every segment register is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 3 | Register number to write |
| wr_base | input | ADDR_W | New base |
| wr_limit | input | 16 | New limit (offset of the last byte) |
| wr_valid | input | 1 | New valid flag |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge |
| req_kind | input | 2 | Access kind: 0 fetch, 1 data, 2 stack, 3 string destination |
| req_ovr | input | 2 | Data override: 0 none, 1 ES, 2 FS, 3 GS |
| req_mode64 | input | 1 | 1 selects flat mode |
| req_offset | input | ADDR_W | Effective offset |
| req_size_m1 | input | SIZE_W | Access size in bytes minus one |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | ADDR_W | Linear address, 0 on a fault |
| rsp_seg | output | 3 | Segment used |
| rsp_limit_fault | output | 1 | Access exceeds the segment limit |
| rsp_inval_fault | output | 1 | Selected segment is not valid |

## Verification
A wrong base, limit or valid flag in a register shows up only when a request selects that segment. It then appears one cycle after acceptance, as a wrong address or a false fault. The sweeps therefore cover every combination of kind, override and mode against distinct bases. An off-by-one in the limit compare shows only at the exact boundary, or where the 16-bit sum wraps. For that reason offsets are swept across each limit and across 0xFFFF, with every access size. A broken hold path shows on the cycle after backpressure begins.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
    localparam int NUM_SEG = 6;
    localparam int SEL_W   = 3;
    localparam int LIM_W   = 16;

    localparam logic [SEL_W-1:0] SEG_CS = 3'd0;
    localparam logic [SEL_W-1:0] SEG_DS = 3'd1;
    localparam logic [SEL_W-1:0] SEG_SS = 3'd2;
    localparam logic [SEL_W-1:0] SEG_ES = 3'd3;
    localparam logic [SEL_W-1:0] SEG_FS = 3'd4;
    localparam logic [SEL_W-1:0] SEG_GS = 3'd5;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_DATA   = 2'd1,
        ACC_STACK  = 2'd2,
        ACC_STRDST = 2'd3
    } acc_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_agu_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_sel,
    input  logic [ADDR_W-1:0]                wr_base,
    input  logic [LIM_W-1:0]                 wr_limit,
    input  logic                             wr_valid,
    output logic [NUM_SEG-1:0][ADDR_W-1:0]   base_o,
    output logic [NUM_SEG-1:0][LIM_W-1:0]    limit_o,
    output logic [NUM_SEG-1:0]               valid_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              valid;
    } seg_t;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        seg_t seg_d, seg_q;

        always_comb begin
            seg_d = seg_q;
            if (wr_en && (wr_sel == SEL_W'(g))) begin
                seg_d.base  = wr_base;
                seg_d.limit = wr_limit;
                seg_d.valid = wr_valid;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) seg_q <= '0;
            else        seg_q <= seg_d;
        end

        assign base_o[g]  = seg_q.base;
        assign limit_o[g] = seg_q.limit;
        assign valid_o[g] = seg_q.valid;
    end
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_agu_pkg::*;
(
    input  logic [1:0]       kind_i,
    input  logic [1:0]       ovr_i,
    output logic [SEL_W-1:0] seg_o
);
    always_comb begin
        unique case (acc_e'(kind_i))
            ACC_FETCH:  seg_o = SEG_CS;
            ACC_STACK:  seg_o = SEG_SS;
            ACC_STRDST: seg_o = SEG_ES;
            default: begin
                unique case (ovr_i)
                    2'd1:    seg_o = SEG_ES;
                    2'd2:    seg_o = SEG_FS;
                    2'd3:    seg_o = SEG_GS;
                    default: seg_o = SEG_DS;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_agu_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 3
) (
    input  logic [SEL_W-1:0]  seg_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LIM_W-1:0]  limit_i,
    input  logic              valid_i,
    input  logic              mode64_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [SIZE_W-1:0] size_m1_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              limit_fault_o,
    output logic              inval_fault_o
);
    localparam int END_W = LIM_W + 1;

    logic [END_W-1:0]  last_byte;
    logic [ADDR_W-1:0] flat_base;
    logic              over;

    assign last_byte = {1'b0, offset_i[LIM_W-1:0]} + END_W'(size_m1_i);
    assign over      = last_byte > {1'b0, limit_i};
    assign flat_base = (seg_i == SEG_FS || seg_i == SEG_GS) ? base_i : '0;

    always_comb begin
        addr_o        = '0;
        limit_fault_o = 1'b0;
        inval_fault_o = 1'b0;
        if (!valid_i) begin
            inval_fault_o = 1'b1;
        end else if (mode64_i) begin
            addr_o = flat_base + offset_i;
        end else if (over) begin
            limit_fault_o = 1'b1;
        end else begin
            addr_o = base_i + ADDR_W'(offset_i[LIM_W-1:0]);
        end
    end
endmodule

// File: rtl/seg_agu.sv
module seg_agu
    import seg_agu_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [15:0]       wr_limit,
    input  logic              wr_valid,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_ovr,
    input  logic              req_mode64,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [SIZE_W-1:0] req_size_m1,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [2:0]        rsp_seg,
    output logic              rsp_limit_fault,
    output logic              rsp_inval_fault
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [SEL_W-1:0]  seg;
        logic              lim_flt;
        logic              inv_flt;
    } rsp_t;

    logic [NUM_SEG-1:0][ADDR_W-1:0] seg_base;
    logic [NUM_SEG-1:0][LIM_W-1:0]  seg_limit;
    logic [NUM_SEG-1:0]             seg_valid;
    logic [SEL_W-1:0]               sel;
    logic [ADDR_W-1:0]              calc_addr;
    logic                           calc_lf, calc_if;
    rsp_t                           rsp_d, rsp_q;

    seg_regfile #(.ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_base(wr_base),
        .wr_limit(wr_limit), .wr_valid(wr_valid),
        .base_o(seg_base), .limit_o(seg_limit), .valid_o(seg_valid)
    );

    seg_select i_sel (
        .kind_i(req_kind), .ovr_i(req_ovr), .seg_o(sel)
    );

    seg_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_chk (
        .seg_i(sel), .base_i(seg_base[sel]), .limit_i(seg_limit[sel]),
        .valid_i(seg_valid[sel]), .mode64_i(req_mode64),
        .offset_i(req_offset), .size_m1_i(req_size_m1),
        .addr_o(calc_addr), .limit_fault_o(calc_lf), .inval_fault_o(calc_if)
    );

    assign req_ready = !rsp_q.valid || rsp_ready;

    always_comb begin
        rsp_d = rsp_q;
        if (rsp_q.valid && rsp_ready) rsp_d.valid = 1'b0;
        if (req_valid && req_ready) begin
            rsp_d.valid   = 1'b1;
            rsp_d.addr    = calc_addr;
            rsp_d.seg     = sel;
            rsp_d.lim_flt = calc_lf;
            rsp_d.inv_flt = calc_if;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid       = rsp_q.valid;
    assign rsp_addr        = rsp_q.addr;
    assign rsp_seg         = rsp_q.seg;
    assign rsp_limit_fault = rsp_q.lim_flt;
    assign rsp_inval_fault = rsp_q.inv_flt;
endmodule

// File: rtl/seg_agu_checker.sv
module seg_agu_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic              req_mode64,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [2:0]        rsp_seg,
    input logic              rsp_limit_fault,
    input logic              rsp_inval_fault
);
    logic acc;
    assign acc = req_valid && req_ready;

    p_fetch_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_kind == 2'd0 |=> rsp_valid && rsp_seg == 3'd0);

    p_strdst_es_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_kind == 2'd3 |=> rsp_valid && rsp_seg == 3'd3);

    p_fault_addr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_limit_fault |-> rsp_addr == '0);

    p_flat_no_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_mode64 |=> !rsp_limit_fault);

    p_inval_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_inval_fault |-> !rsp_limit_fault && rsp_addr == '0);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_seg));

    p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);
endmodule

bind seg_agu seg_agu_checker #(.ADDR_W(ADDR_W)) i_seg_agu_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_mode64(req_mode64), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_seg(rsp_seg),
    .rsp_limit_fault(rsp_limit_fault), .rsp_inval_fault(rsp_inval_fault)
);

// File: tb/test_seg_agu.sv
`timescale 1ns/1ps
module test_seg_agu;
    localparam int AW = 64;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [AW-1:0] wr_base = '0;
    logic [15:0]   wr_limit = '0;
    logic          wr_valid = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [1:0]    req_ovr = '0;
    logic          req_mode64 = 1'b0;
    logic [AW-1:0] req_offset = '0;
    logic [SW-1:0] req_size_m1 = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [AW-1:0] rsp_addr;
    logic [2:0]    rsp_seg;
    logic          rsp_limit_fault;
    logic          rsp_inval_fault;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] m_base [6];
    logic [15:0]   m_lim  [6];
    logic          m_vld  [6];

    seg_agu #(.ADDR_W(AW), .SIZE_W(SW)) i_seg_agu (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [AW-1:0] b, input logic [15:0] l, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_base = b; wr_limit = l; wr_valid = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (sel < 6) begin m_base[sel] = b; m_lim[sel] = l; m_vld[sel] = v; end
    endtask

    task automatic rq(input int kind, input int ovr, input logic m64,
                      input logic [AW-1:0] ofs, input int sz);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_ovr = 2'(ovr);
        req_mode64 = m64; req_offset = ofs; req_size_m1 = SW'(sz);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    function automatic int exp_seg(input int kind, input int ovr);
        if (kind == 0) return 0;
        if (kind == 2) return 2;
        if (kind == 3) return 3;
        if (ovr == 1) return 3;
        if (ovr == 2) return 4;
        if (ovr == 3) return 5;
        return 1;
    endfunction

    task automatic full_check(input string tag, input int kind, input int ovr,
                              input logic m64, input logic [AW-1:0] ofs, input int sz);
        int s;
        logic [AW-1:0] ea;
        logic elf, eif;
        s = exp_seg(kind, ovr);
        eif = !m_vld[s];
        elf = 1'b0;
        ea = '0;
        if (!eif) begin
            if (m64) ea = ((s >= 4) ? m_base[s] : '0) + ofs;
            else if (int'(ofs[15:0]) + sz > int'(m_lim[s])) elf = 1'b1;
            else ea = m_base[s] + AW'(ofs[15:0]);
        end
        rq(kind, ovr, m64, ofs, sz);
        chk({tag, " valid"}, AW'(rsp_valid), 1);
        chk({tag, " seg"}, AW'(rsp_seg), AW'(s));
        chk({tag, " addr"}, rsp_addr, ea);
        chk({tag, " limit fault"}, AW'(rsp_limit_fault), AW'(elf));
        chk({tag, " inval fault"}, AW'(rsp_inval_fault), AW'(eif));
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) begin m_base[i] = '0; m_lim[i] = '0; m_vld[i] = 1'b0; end
        #25 rst_n = 1'b1;
        #1;
        // R11: reset state
        chk("R11 rsp_valid after reset", AW'(rsp_valid), 0);
        chk("R10 req_ready when idle", AW'(req_ready), 1);
        full_check("R11 CS invalid after reset", 0, 0, 1'b0, 64'h10, 0);

        for (int i = 0; i < 6; i++)
            wr(i, 64'h0000_0100_0000_0000 * (i + 1) + 64'h111 * i, 16'hFFFF, 1'b1);
        // R9: out-of-range select changes nothing
        wr(6, 64'hDEAD_0000, 16'h0, 1'b0);
        wr(7, 64'hBEEF_0000, 16'h0, 1'b0);
        full_check("R9 ignored select", 1, 0, 1'b0, 64'h40, 0);
        full_check("R9 ignored select GS", 1, 3, 1'b1, 64'h40, 0);

        // R1 R2 R3 R4 R6: every kind, override, mode
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 4; k++)
                for (int o = 0; o < 4; o++)
                    full_check("R1/R2/R3/R4/R6 sweep", k, o, m[0], 64'h0000_0001_0000_1234, 0);

        // R4: base wraps modulo 2^ADDR_W
        wr(1, 64'hFFFF_FFFF_FFFF_FFF0, 16'hFFFF, 1'b1);
        full_check("R4 base wrap", 1, 0, 1'b0, 64'h20, 0);
        chk("R4 wrap value", rsp_addr, 64'h10);

        // R5: limit sweep across boundaries and sizes
        foreach (m_lim[j]) begin end
        for (int li = 0; li < 5; li++) begin
            logic [15:0] lim;
            case (li)
                0: lim = 16'h0000;
                1: lim = 16'h0001;
                2: lim = 16'h00FF;
                3: lim = 16'h7FFE;
                default: lim = 16'hFFFF;
            endcase
            wr(1, 64'h0000_0000_0005_0000, lim, 1'b1);
            for (int d = -8; d <= 8; d++) begin
                int ofs;
                ofs = int'(lim) + d;
                if (ofs < 0 || ofs > 16'hFFFF) continue;
                for (int sz = 0; sz < 8; sz++)
                    full_check("R5 limit sweep", 1, 0, 1'b0, AW'(ofs), sz);
            end
            for (int ofs = 16'hFFF8; ofs <= 16'hFFFF; ofs++)
                for (int sz = 0; sz < 8; sz++)
                    full_check("R5 wrap sweep", 1, 0, 1'b0, AW'(ofs), sz);
        end
        // R5: explicit wrap corner
        wr(1, 64'h0, 16'hFFFF, 1'b1);
        rq(1, 0, 1'b0, 64'hFFFF, 1);
        chk("R5 wrap past 0xFFFF faults", AW'(rsp_limit_fault), 1);

        // R7: flat mode never limit faults
        wr(1, 64'h0, 16'h0000, 1'b1);
        for (int sz = 0; sz < 8; sz++)
            full_check("R7 flat no limit", 1, 0, 1'b1, 64'h0000_0000_0000_FFFF, sz);
        rq(1, 0, 1'b1, 64'h1234_5678_9ABC_DEF0, 7);
        chk("R7 flat limit fault low", AW'(rsp_limit_fault), 0);
        chk("R6 flat DS addr is offset", rsp_addr, 64'h1234_5678_9ABC_DEF0);

        // R8: invalid segment in both modes
        wr(4, 64'h7000, 16'hFFFF, 1'b0);
        full_check("R8 invalid FS seg mode", 1, 2, 1'b0, 64'h10, 0);
        full_check("R8 invalid FS flat mode", 1, 2, 1'b1, 64'h10, 0);
        rq(1, 2, 1'b0, 64'hFFFF, 7);
        chk("R8 inval precedence", AW'({rsp_inval_fault, rsp_limit_fault}), 2);

        // R10: backpressure holds response
        wr(0, 64'h0000_0000_0000_8000, 16'hFFFF, 1'b1);
        @(negedge clk); rsp_ready = 1'b0;
        rq(0, 0, 1'b0, 64'h22, 0);
        chk("R10 A valid", AW'(rsp_valid), 1);
        chk("R10 A addr", rsp_addr, 64'h8022);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd3; req_ovr = 2'd0; req_mode64 = 1'b1; req_offset = 64'h99;
        #1 chk("R10 ready low under backpressure", AW'(req_ready), 0);
        @(posedge clk); #1;
        chk("R10 held addr", rsp_addr, 64'h8022);
        chk("R10 held seg", AW'(rsp_seg), 0);
        @(negedge clk); rsp_ready = 1'b1;
        #1 chk("R10 ready follows rsp_ready", AW'(req_ready), 1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk("R10 B seg", AW'(rsp_seg), 3);
        chk("R10 B addr", rsp_addr, 64'h99);
        @(posedge clk); #1;
        chk("R10 drained", AW'(rsp_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule